// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block sits behind a 10-bit ADC sample stream and fills an on-chip sample buffer once a chosen trigger condition occurs. Before arming, the host sets five values: a trigger mode, a post-trigger delay in clock cycles, a number of pre-trigger samples to keep, a capture length and a decimation ratio. An arm pulse latches these values and starts the capture. While the controller waits for the trigger, it keeps the most recent decimated samples in a circular region at the bottom of the buffer. When the trigger is accepted, it waits for the programmed delay and then stores post-trigger samples right after the retained pre-trigger ones, until the capture length is reached.

When the capture is complete, the controller raises `done` and stops writing. The host then reads the buffer through an index port. Index 0 is always the oldest retained pre-trigger sample, so the readback comes out in time order whatever position the circular region had reached when the trigger came. The number of pre-trigger samples actually kept and the total number stored are both reported, because a trigger that arrives early leaves the pre-trigger region only partly filled.

Top module: `trig_capture_ctrl`

## Requirements
- R1: In reset, and after it, `busy` and `done` are 0, and `pre_count` and `stored_count` are 0.
- R2: An `arm` pulse latches the configuration, clears `done` and both counts, and sets `busy` from the next cycle. A trigger condition seen while idle, on the arm cycle itself, or during the delay or post-trigger phase has no effect.
- R3: The trigger mode encodings are: 0 is a rising edge of `trig_in`, 1 is a falling edge, 2 is `trig_in` high, and 3 is `trig_in` low. Edges are judged against the level of `trig_in` on the previous clock.
- R4: Take a trigger accepted at clock edge t with delay D. The first sample that can be stored after the trigger is the one presented at edge t+1+D. No post-trigger sample is stored before that edge.
- R5: While waiting, decimated samples are kept in a circular region of P entries. P is the requested pre-trigger count clamped to the effective length minus 1. `pre_count` reports how many were actually held, and this can be fewer than P if the trigger comes early.
- R6: With a decimation ratio N, only the first of every N valid samples is stored; a ratio of 0 or 1 stores every valid sample. The decimation phase restarts at arm and when the trigger is accepted.
- R7: The effective length is the requested length clamped to DEPTH, and a requested length of 0 is treated as 1. `stored_count` never exceeds DEPTH.
- R8: When `stored_count` reaches the effective length, `busy` falls and `done` rises on the same edge. Later samples and triggers change neither the counts nor the buffer contents until the next arm.
- R9: `rd_data` returns, one clock after `rd_idx` is applied, the sample of time-ordered index `rd_idx`. Index 0 is the oldest retained pre-trigger sample, and the post-trigger samples follow the pre-trigger ones.
- R10: `stored_count` equals `pre_count` plus the number of post-trigger samples stored, and it never decreases except at arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trig_mode | input | 2 | Trigger condition select (R3 encoding) |
| cfg_delay | input | DLY_W | Post-trigger delay in clock cycles |
| cfg_pre | input | LEN_W | Requested pre-trigger samples |
| cfg_length | input | LEN_W | Requested total samples |
| cfg_decim | input | DEC_W | Decimation ratio |
| arm | input | 1 | Start-capture pulse |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 10 | Sample value |
| trig_in | input | 1 | Trigger signal |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture complete |
| pre_count | output | CNT_W | Pre-trigger samples held |
| stored_count | output | CNT_W | Total samples stored |
| rd_idx | input | AW | Time-ordered read index |
| rd_data | output | 10 | Sample at `rd_idx`, one clock later |

## Verification
Every status output is a register, so a sample or trigger presented before edge t shows up in `busy`, `done` and the counts right after edge t. The bench drives inputs on the falling edge, advances its model on the rising edge and compares on the next falling edge, so the model and the design are compared at the same point each cycle. A trigger accepted at edge t with delay D leaves `stored_count` equal to `pre_count` up to edge t+D. The bench checks this on every cycle of the delay phase. A read index set on one falling edge is compared on the following falling edge, after the single read register has loaded.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int SAMPLE_W = 10;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic    valid;
        sample_t data;
    } sample_beat_t;

    typedef enum logic [1:0] {
        TRG_RISE = 2'd0,
        TRG_FALL = 2'd1,
        TRG_HIGH = 2'd2,
        TRG_LOW  = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_DELAY = 2'd2,
        ST_POST  = 2'd3
    } cap_state_e;

    // Time-ordered index -> physical slot. Slots below 'held' form the
    // circular pre-trigger ring starting at 'oldest'; the rest are linear.
    function automatic int unsigned cap_phys_index(int unsigned idx,
                                                   int unsigned held,
                                                   int unsigned oldest);
        int unsigned s;
        if (idx >= held) return idx;
        s = oldest + idx;
        if (s >= held) s = s - held;
        return s;
    endfunction

endpackage

// File: rtl/cap_trig_qual.sv
module cap_trig_qual
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_in,
    input  trig_mode_e mode,
    output logic       hit
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    always_comb begin
        unique case (mode)
            TRG_RISE: hit =  trig_in && !trig_q;
            TRG_FALL: hit = !trig_in &&  trig_q;
            TRG_HIGH: hit =  trig_in;
            default:  hit = !trig_in;
        endcase
    end
endmodule

// File: rtl/cap_decim.sv
module cap_decim #(
    parameter int DEC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             valid,
    input  logic [DEC_W-1:0] ratio,
    output logic             take
);
    logic [DEC_W-1:0] phase;
    logic [DEC_W:0]   phase_inc;

    assign phase_inc = {1'b0, phase} + (DEC_W+1)'(1);
    assign take      = valid && (phase == '0);

    always_ff @(posedge clk) begin
        if (rst || clear)
            phase <= '0;
        else if (valid)
            phase <= (phase_inc >= {1'b0, ratio}) ? '0 : phase_inc[DEC_W-1:0];
    end
endmodule

// File: rtl/cap_sample_ram.sv
module cap_sample_ram
    import cap_pkg::*;
#(
    parameter int DEPTH = 1021,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sample_t       wdata,
    input  logic [AW-1:0] raddr,
    output sample_t       rdata
);
    sample_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import cap_pkg::*;
#(
    parameter  int DEPTH = 1021,
    parameter  int LEN_W = 16,
    parameter  int DEC_W = 16,
    parameter  int DLY_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_trig_mode,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [LEN_W-1:0] cfg_pre,
    input  logic [LEN_W-1:0] cfg_length,
    input  logic [DEC_W-1:0] cfg_decim,
    input  logic             arm,
    input  logic             smp_valid,
    input  logic [9:0]       smp_data,
    input  logic             trig_in,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] pre_count,
    output logic [CNT_W-1:0] stored_count,
    input  logic [AW-1:0]    rd_idx,
    output logic [9:0]       rd_data
);
    cap_state_e       state;
    trig_mode_e       mode_q;
    logic [DLY_W-1:0] delay_q, dly_cnt;
    logic [DEC_W-1:0] ratio_q;
    logic [CNT_W-1:0] len_q, pre_q;
    logic [CNT_W-1:0] pre_cnt, post_cnt, pre_ptr, oldest;
    logic [LEN_W-1:0] len_c, pre_c;
    logic             hit, take, dec_clear, we;
    logic [AW-1:0]    waddr, raddr;
    sample_beat_t     beat;

    assign beat = '{valid: smp_valid, data: smp_data};

    // Clamp requested sizes before latching them.
    always_comb begin
        if (cfg_length == '0)                 len_c = LEN_W'(1);
        else if (cfg_length > LEN_W'(DEPTH))  len_c = LEN_W'(DEPTH);
        else                                  len_c = cfg_length;
        pre_c = (cfg_pre > len_c - LEN_W'(1)) ? len_c - LEN_W'(1) : cfg_pre;
    end

    cap_trig_qual u_trig (
        .clk (clk), .rst (rst), .trig_in (trig_in), .mode (mode_q), .hit (hit)
    );

    assign dec_clear = arm || (state == ST_PRE && hit) ||
                       (state != ST_PRE && state != ST_POST);

    cap_decim #(.DEC_W(DEC_W)) u_decim (
        .clk (clk), .rst (rst), .clear (dec_clear),
        .valid (beat.valid), .ratio (ratio_q), .take (take)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            mode_q   <= TRG_RISE;
            delay_q  <= '0;
            dly_cnt  <= '0;
            ratio_q  <= '0;
            len_q    <= '0;
            pre_q    <= '0;
            pre_cnt  <= '0;
            post_cnt <= '0;
            pre_ptr  <= '0;
        end else if (arm) begin
            state    <= ST_PRE;
            done     <= 1'b0;
            mode_q   <= trig_mode_e'(cfg_trig_mode);
            delay_q  <= cfg_delay;
            ratio_q  <= cfg_decim;
            len_q    <= CNT_W'(len_c);
            pre_q    <= CNT_W'(pre_c);
            pre_cnt  <= '0;
            post_cnt <= '0;
            pre_ptr  <= '0;
        end else begin
            unique case (state)
                ST_PRE: begin
                    if (take && pre_q != '0) begin
                        pre_ptr <= (pre_ptr + CNT_W'(1) == pre_q) ? '0 : pre_ptr + CNT_W'(1);
                        if (pre_cnt != pre_q) pre_cnt <= pre_cnt + CNT_W'(1);
                    end
                    if (hit) begin
                        if (delay_q == '0) state <= ST_POST;
                        else begin
                            state   <= ST_DELAY;
                            dly_cnt <= delay_q - DLY_W'(1);
                        end
                    end
                end
                ST_DELAY: begin
                    if (dly_cnt == '0) state <= ST_POST;
                    else               dly_cnt <= dly_cnt - DLY_W'(1);
                end
                ST_POST: begin
                    if (take) begin
                        post_cnt <= post_cnt + CNT_W'(1);
                        if (pre_cnt + post_cnt + CNT_W'(1) == len_q) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Write side: ring during pre-trigger, linear after it.
    assign we    = !arm && take &&
                   ((state == ST_PRE && pre_q != '0) || state == ST_POST);
    assign waddr = (state == ST_PRE) ? AW'(pre_ptr) : AW'(pre_cnt + post_cnt);

    // Read side: time-ordered index mapped onto the ring.
    assign oldest = (pre_cnt == pre_q) ? pre_ptr : '0;
    assign raddr  = AW'(cap_phys_index(32'(rd_idx), 32'(pre_cnt), 32'(oldest)));

    cap_sample_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk (clk), .we (we), .waddr (waddr), .wdata (beat.data),
        .raddr (raddr), .rdata (rd_data)
    );

    assign busy         = (state != ST_IDLE);
    assign pre_count    = pre_cnt;
    assign stored_count = pre_cnt + post_cnt;
endmodule

module trig_capture_ctrl_chk #(
    parameter int DEPTH = 1021,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             arm,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] pre_count,
    input logic [CNT_W-1:0] stored_count
);
    AST_DONE_EXCL:   assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R8
    AST_ARM_RESTART: assert property (@(posedge clk) disable iff (rst) arm |=> busy && !done && stored_count == '0); // R2
    AST_IDLE_STAYS:  assert property (@(posedge clk) disable iff (rst) !busy && !arm |=> !busy); // R2
    AST_DONE_HOLDS:  assert property (@(posedge clk) disable iff (rst) done && !arm |=> done && $stable(stored_count)); // R8
    AST_PRE_WITHIN:  assert property (@(posedge clk) disable iff (rst) pre_count <= stored_count); // R5
    AST_STORED_MONO: assert property (@(posedge clk) disable iff (rst) busy && !arm |=> stored_count >= $past(stored_count)); // R10
    AST_CAP_BOUND:   assert property (@(posedge clk) disable iff (rst) 32'(stored_count) <= DEPTH); // R7
endmodule

bind trig_capture_ctrl trig_capture_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk (clk), .rst (rst), .arm (arm), .busy (busy), .done (done),
    .pre_count (pre_count), .stored_count (stored_count)
);

// File: tb/trig_capture_ctrl_tb_top.sv
module trig_capture_ctrl_tb_top;
    localparam int DEPTH = 40;
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 0, rst = 1;
    logic [1:0]       cfg_trig_mode = 0;
    logic [31:0]      cfg_delay = 0;
    logic [15:0]      cfg_pre = 0, cfg_length = 0, cfg_decim = 0;
    logic             arm = 0, smp_valid = 0, trig_in = 0;
    logic [9:0]       smp_data = 0;
    logic             busy, done;
    logic [CNT_W-1:0] pre_count, stored_count;
    logic [AW-1:0]    rd_idx = 0;
    logic [9:0]       rd_data;

    int checks = 0, fails = 0;
    bit compare_on = 0;

    always #4 clk = ~clk; // 125 MHz

    trig_capture_ctrl #(.DEPTH(DEPTH)) dut_i (.*);

    // ---------------- behavioural reference model ----------------
    int  ms = 0, mM = 0, mL = 0, mP = 0, mN = 1, mdec = 0;
    longint mD = 0, mdl = 0;
    bit  mdone = 0, mtq = 0;
    int  preq[$], postq[$];

    always @(posedge clk) begin : model
        bit hit, take;
        int nst;
        if (rst) begin
            ms = 0; mdone = 0; mdec = 0; mtq = 0;
            preq.delete(); postq.delete();
        end else begin
            case (mM)
                0: hit = trig_in && !mtq;
                1: hit = !trig_in && mtq;
                2: hit = trig_in;
                default: hit = !trig_in;
            endcase
            take = smp_valid && (mdec == 0);
            nst  = ms;
            if (arm) begin
                mM = int'(cfg_trig_mode); mD = longint'(cfg_delay);
                mN = (cfg_decim == 0) ? 1 : int'(cfg_decim);
                mL = (cfg_length == 0) ? 1 : ((int'(cfg_length) > DEPTH) ? DEPTH : int'(cfg_length));
                mP = (int'(cfg_pre) > mL - 1) ? mL - 1 : int'(cfg_pre);
                nst = 1; mdone = 0; preq.delete(); postq.delete();
            end else begin
                case (ms)
                    1: begin
                        if (take && mP > 0) begin
                            preq.push_back(int'(smp_data));
                            if (preq.size() > mP) void'(preq.pop_front());
                        end
                        if (hit) begin
                            if (mD == 0) nst = 3;
                            else begin nst = 2; mdl = mD; end
                        end
                    end
                    2: begin mdl--; if (mdl == 0) nst = 3; end
                    3: if (take) begin
                        postq.push_back(int'(smp_data));
                        if (preq.size() + postq.size() == mL) begin nst = 0; mdone = 1; end
                    end
                    default: ;
                endcase
            end
            if (arm || (ms == 1 && hit) || (ms != 1 && ms != 3)) mdec = 0;
            else if (smp_valid) mdec = (mdec + 1 >= mN) ? 0 : mdec + 1;
            ms  = nst;
            mtq = trig_in;
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (compare_on && !rst) begin
            chk("R2",  int'(busy), int'(ms != 0), "busy");
            chk("R8",  int'(done), int'(mdone), "done");
            chk("R5",  int'(pre_count), preq.size(), "pre_count");
            chk("R10", int'(stored_count), preq.size() + postq.size(), "stored_count");
            if (ms == 2) chk("R4", int'(stored_count), int'(pre_count), "no post sample during delay");
        end
    end

    int dval = 0;

    task automatic run_capture(int mode, int dly, int pre, int len, int dec,
                               int trig_at, int vmod, int exp_len, string tag);
        bit idle_lvl, act_lvl;
        int expv[$];
        idle_lvl = (mode == 1 || mode == 3);
        act_lvl  = !idle_lvl;
        @(negedge clk); trig_in = idle_lvl; smp_valid = 0;
        @(negedge clk);
        cfg_trig_mode = 2'(mode); cfg_delay = 32'(dly); cfg_pre = 16'(pre);
        cfg_length = 16'(len); cfg_decim = 16'(dec); arm = 1;
        @(negedge clk); arm = 0;
        for (int c = 0; c < 4000; c++) begin
            smp_valid = (vmod <= 1) || (c % vmod != 0);
            if (smp_valid) begin smp_data = 10'(dval); dval++; end
            trig_in = (c >= trig_at && c < trig_at + 2) ? act_lvl : idle_lvl;
            @(negedge clk);
            if (mdone && c > trig_at + 1) break;
        end
        // R8: stimulus after completion must be ignored
        for (int c = 0; c < 6; c++) begin
            smp_valid = 1; smp_data = 10'(dval); dval++;
            trig_in = c[0];
            @(negedge clk);
        end
        smp_valid = 0; trig_in = idle_lvl;
        chk("R3", int'(done), 1, "capture completed for mode");
        chk("R7", int'(stored_count), exp_len, "effective length");
        chk("R8", int'(busy), 0, "idle after done");
        expv = {preq, postq};
        for (int i = 0; i < expv.size(); i++) begin
            rd_idx = AW'(i);
            @(negedge clk);
            chk(tag, int'(rd_data), expv[i], $sformatf("readback index %0d", i));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'(busy), 0, "busy in reset");
        chk("R1", int'(done), 0, "done in reset");
        chk("R1", int'(stored_count), 0, "stored in reset");
        rst = 0;
        @(negedge clk);
        chk("R1", int'(pre_count), 0, "pre after reset");
        compare_on = 1;
        // R2: trigger pulses while idle do nothing
        trig_in = 1; @(negedge clk); trig_in = 0; @(negedge clk);
        chk("R2", int'(busy), 0, "trigger before arm ignored");
        run_capture(0, 0, 0, 10, 1, 5, 1, 10, "R9");     // rising, plain
        run_capture(1, 5, 4, 12, 1, 20, 3, 12, "R9");    // falling, delay, ring wrap
        run_capture(2, 0, 3, 9, 3, 15, 1, 9, "R6");      // high level, decimate by 3
        run_capture(3, 2, 8, 20, 0, 2, 1, 20, "R6");     // low level, ratio 0, early trigger
        chk("R5", int'(pre_count < 8), 1, "early trigger keeps fewer presamples");
        run_capture(0, 1000, 5, 100, 2, 10, 2, 40, "R4"); // long delay, length clamp
        run_capture(0, 0, 50, 30, 1, 60, 1, 30, "R5");   // presample clamp to length-1
        chk("R5", int'(pre_count), 29, "presamples clamped");
        run_capture(2, 0, 0, 0, 1, 4, 1, 1, "R7");       // length 0 -> 1
        compare_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule